// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit

This block holds two independent multiply-accumulate lanes. On each clock with the input strobe high, each lane takes one 16-bit half from each of two shared 32-bit operand words, multiplies the two halves, and then does one of three things with the product. It can replace its 40-bit accumulator with the product, add the product to the accumulator, or subtract the product from it. Eight guard bits above the 32-bit product range let long sums grow without loss.

Each lane has its own controls. These choose the half of each operand word, signed or unsigned operands, and the operation. A shared control chooses whether an accumulation that leaves the 40-bit range wraps or clamps.

Two narrowed views of each accumulator are always present at the outputs. The first is a 16-bit value, rounded at bit 15 and saturated. The second is a 32-bit value, saturated. Each view has its own overflow flag.

Top module: `dual_mac`

## Requirements
- R1: After an active-low reset, both accumulators are zero. Every extracted result and every overflow flag is also zero.
- R2: Each lane picks its A operand from `opa_word`. It takes bits 31:16 when its bit of `hi_a` is 1 and bits 15:0 when that bit is 0. The B operand is picked from `opb_word` by `hi_b` in the same way.
- R3: When a lane's bit of `signed_mode` is 1, both of its operands are read as two's complement. When the bit is 0, both are read as unsigned. An unsigned load never leaves the accumulator negative.
- R4: The 2-bit field `op_sel[2i+1:2i]` of lane i selects the operation: 00 hold, 01 load product, 10 add product, 11 subtract product. While `in_valid` is 0, both accumulators hold their values.
- R5: The accumulator shows the effect of an operation on the clock edge that samples it. A new operation is accepted on every cycle.
- R6: With `sat_acc` at 0, an add or subtract that leaves the signed 40-bit range wraps modulo 2^40.
- R7: With `sat_acc` at 1, such a result clamps to 2^39-1 or to -2^39.
- R8: The 16-bit result equals (acc + 2^15) shifted arithmetically right by 16, whenever that value fits in a signed 16-bit field.
- R9: When the rounded value does not fit, the 16-bit result is 0x7FFF or 0x8000, matching the sign, and the lane's `ovf16` bit is 1. Otherwise `ovf16` is 0.
- R10: The 32-bit result is acc when acc fits in signed 32 bits, and `ovf32` is then 0. Otherwise the result is 0x7FFFFFFF or 0x80000000, matching the sign, and `ovf32` is 1.
- R11: The two lanes are independent. A lane's controls never change the other lane's accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe for both lanes |
| opa_word | input | 32 | Word supplying the A operands |
| opb_word | input | 32 | Word supplying the B operands |
| hi_a | input | 2 | Per lane: 1 selects the upper half of opa_word |
| hi_b | input | 2 | Per lane: 1 selects the upper half of opb_word |
| op_sel | input | 4 | Per lane 2-bit operation code |
| signed_mode | input | 2 | Per lane: 1 signed, 0 unsigned |
| sat_acc | input | 1 | 1 clamps accumulation at 40 bits, 0 wraps |
| acc_out | output | 80 | Accumulators, lane i at bits 40i+39:40i |
| res16_out | output | 32 | Rounded, saturated 16-bit results, lane i at 16i+15:16i |
| ovf16 | output | 2 | 16-bit extraction overflow per lane |
| res32_out | output | 64 | Saturated 32-bit results, lane i at 32i+31:32i |
| ovf32 | output | 2 | 32-bit extraction overflow per lane |

## Verification
Several properties are checked on every cycle:
- the accumulator holds while the strobe is low;
- a load places exactly the multiplier's product in the accumulator one edge later;
- an unsigned load is never negative;
- a clamping add of a non-negative product onto a non-negative accumulator stays non-negative;
- a raised overflow flag always comes with an extreme result value.

Other behaviour can only be shown by the bench's scenarios: the exact arithmetic of rounding, the exact point of wrap versus clamp after long runs of accumulation, the half selection, and lane independence. The bench checks these against a behavioural model on every clock.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        MAC_HOLD = 2'b00,
        MAC_LOAD = 2'b01,
        MAC_ADD  = 2'b10,
        MAC_SUB  = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    input  logic              is_signed,
    output logic [2*OP_W:0]   prod
);
    localparam int EXT_W = OP_W + 1;
    logic signed [EXT_W-1:0] a_ext, b_ext;
    logic signed [2*EXT_W-1:0] full;

    always_comb begin
        a_ext = $signed({is_signed & a_in[OP_W-1], a_in});
        b_ext = $signed({is_signed & b_in[OP_W-1], b_in});
        full  = a_ext * b_ext;
        prod  = full[2*OP_W:0];
    end
endmodule

// File: rtl/mac_lane.sv
module mac_lane
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  a_in,
    input  logic [OP_W-1:0]  b_in,
    input  logic             is_signed,
    input  logic [1:0]       op,
    input  logic             sat_acc,
    output logic [ACC_W-1:0] acc
);
    localparam int PROD_W = 2*OP_W + 1;
    localparam int SUM_W  = ACC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  prod_x, acc_x, sum;
    mac_op_e           op_e;

    mac_mult #(.OP_W(OP_W)) u_mult (
        .a_in(a_in), .b_in(b_in), .is_signed(is_signed), .prod(prod)
    );

    always_comb begin
        st_d   = st_q;
        op_e   = mac_op_e'(op);
        prod_x = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
        acc_x  = {st_q.acc[ACC_W-1], st_q.acc};
        sum    = (op_e == MAC_SUB) ? acc_x - prod_x : acc_x + prod_x;
        if (in_valid) begin
            case (op_e)
                MAC_LOAD: st_d.acc = prod_x[ACC_W-1:0];
                MAC_ADD, MAC_SUB: begin
                    if (sat_acc && (sum[SUM_W-1] != sum[ACC_W-1]))
                        st_d.acc = sum[SUM_W-1] ? {1'b1, {(ACC_W-1){1'b0}}}
                                                : {1'b0, {(ACC_W-1){1'b1}}};
                    else
                        st_d.acc = sum[ACC_W-1:0];
                end
                default: st_d.acc = st_q.acc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;

    // R5: a load shows the multiplier's product on the next edge
    assert_load_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == MAC_LOAD) |=> (acc == $past(prod_x[ACC_W-1:0])));

    // R3: an unsigned product is never negative
    assert_unsigned_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == MAC_LOAD && !is_signed) |=> !acc[ACC_W-1]);

    // R7: a clamped add of non-negative values cannot wrap to negative
    assert_sat_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_acc && op == MAC_ADD && !acc[ACC_W-1] && !prod[PROD_W-1])
        |=> !acc[ACC_W-1]);

    // R4: hold while the strobe is low
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc));
endmodule

// File: rtl/mac_extract.sv
module mac_extract #(
    parameter int ACC_W = 40,
    parameter int NAR_W = 16,
    parameter int WID_W = 32
) (
    input  logic [ACC_W-1:0] acc,
    output logic [NAR_W-1:0] res_n,
    output logic             ovf_n,
    output logic [WID_W-1:0] res_w,
    output logic             ovf_w
);
    localparam int RND_W = ACC_W + 1;
    localparam int SH_W  = RND_W - NAR_W;

    logic [RND_W-1:0] rnd;
    logic [SH_W-1:0]  shifted;
    logic             fit_n, fit_w;

    always_comb begin
        rnd     = {acc[ACC_W-1], acc} + (RND_W'(1) << (NAR_W-1));
        shifted = rnd[RND_W-1:NAR_W];
        fit_n   = (shifted[SH_W-1:NAR_W-1] == '0) || (shifted[SH_W-1:NAR_W-1] == '1);
        ovf_n   = !fit_n;
        if (fit_n)
            res_n = shifted[NAR_W-1:0];
        else
            res_n = shifted[SH_W-1] ? {1'b1, {(NAR_W-1){1'b0}}} : {1'b0, {(NAR_W-1){1'b1}}};

        fit_w = (acc[ACC_W-1:WID_W-1] == '0) || (acc[ACC_W-1:WID_W-1] == '1);
        ovf_w = !fit_w;
        if (fit_w)
            res_w = acc[WID_W-1:0];
        else
            res_w = acc[ACC_W-1] ? {1'b1, {(WID_W-1){1'b0}}} : {1'b0, {(WID_W-1){1'b1}}};
    end
endmodule

// File: rtl/dual_mac.sv
module dual_mac #(
    parameter int LANES = 2,
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [2*OP_W-1:0]         opa_word,
    input  logic [2*OP_W-1:0]         opb_word,
    input  logic [LANES-1:0]          hi_a,
    input  logic [LANES-1:0]          hi_b,
    input  logic [2*LANES-1:0]        op_sel,
    input  logic [LANES-1:0]          signed_mode,
    input  logic                      sat_acc,
    output logic [LANES*ACC_W-1:0]    acc_out,
    output logic [LANES*OP_W-1:0]     res16_out,
    output logic [LANES-1:0]          ovf16,
    output logic [LANES*2*OP_W-1:0]   res32_out,
    output logic [LANES-1:0]          ovf32
);
    localparam int WID_W = 2*OP_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OP_W-1:0]  a_sel, b_sel;
        logic [ACC_W-1:0] acc_l;
        logic [OP_W-1:0]  r16;
        logic [WID_W-1:0] r32;

        assign a_sel = hi_a[g] ? opa_word[WID_W-1:OP_W] : opa_word[OP_W-1:0];
        assign b_sel = hi_b[g] ? opb_word[WID_W-1:OP_W] : opb_word[OP_W-1:0];

        mac_lane #(.OP_W(OP_W), .ACC_W(ACC_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
            .a_in(a_sel), .b_in(b_sel), .is_signed(signed_mode[g]),
            .op(op_sel[2*g+:2]), .sat_acc(sat_acc), .acc(acc_l)
        );

        mac_extract #(.ACC_W(ACC_W), .NAR_W(OP_W), .WID_W(WID_W)) u_ext (
            .acc(acc_l), .res_n(r16), .ovf_n(ovf16[g]),
            .res_w(r32), .ovf_w(ovf32[g])
        );

        assign acc_out[g*ACC_W+:ACC_W]   = acc_l;
        assign res16_out[g*OP_W+:OP_W]   = r16;
        assign res32_out[g*WID_W+:WID_W] = r32;

        // R9: an overflowing 16-bit extraction reports an extreme value
        assert_ovf16_extreme_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ovf16[g] |-> (r16 == {1'b1, {(OP_W-1){1'b0}}} || r16 == {1'b0, {(OP_W-1){1'b1}}}));

        // R10: an overflowing 32-bit extraction reports an extreme value
        assert_ovf32_extreme_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ovf32[g] |-> (r32 == {1'b1, {(WID_W-1){1'b0}}} || r32 == {1'b0, {(WID_W-1){1'b1}}}));

        // R10: without overflow the 32-bit result carries the same sign as the accumulator
        assert_res32_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !ovf32[g] |-> (r32[WID_W-1] == acc_l[ACC_W-1]));
    end
endmodule

// File: tb/test_dual_mac.sv
module test_dual_mac;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [31:0] opa_word = 0, opb_word = 0;
    logic [1:0]  hi_a = 0, hi_b = 0, signed_mode = 0;
    logic [3:0]  op_sel = 0;
    logic        sat_acc = 0;
    logic [79:0] acc_out;
    logic [31:0] res16_out;
    logic [1:0]  ovf16, ovf32;
    logic [63:0] res32_out;

    int checks = 0, fails = 0;
    longint macc [2];
    bit running = 1;

    dual_mac i_dual_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa_word(opa_word),
        .opb_word(opb_word), .hi_a(hi_a), .hi_b(hi_b), .op_sel(op_sel),
        .signed_mode(signed_mode), .sat_acc(sat_acc), .acc_out(acc_out),
        .res16_out(res16_out), .ovf16(ovf16), .res32_out(res32_out), .ovf32(ovf32)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam longint MAX40 = (64'sd1 <<< 39) - 1;
    localparam longint MIN40 = -(64'sd1 <<< 39);

    function automatic longint opnd(logic [15:0] h, bit sg);
        return sg ? longint'($signed(h)) : longint'(h);
    endfunction

    function automatic longint model_next(int ln, longint cur);
        longint a, b, p, s;
        logic [15:0] ha, hb;
        ha = hi_a[ln] ? opa_word[31:16] : opa_word[15:0];
        hb = hi_b[ln] ? opb_word[31:16] : opb_word[15:0];
        a = opnd(ha, signed_mode[ln]);
        b = opnd(hb, signed_mode[ln]);
        p = a * b;
        if (!in_valid) return cur;
        case (op_sel[2*ln+:2])
            2'b01: return p;
            2'b10: s = cur + p;
            2'b11: s = cur - p;
            default: return cur;
        endcase
        if (sat_acc) begin
            if (s > MAX40) return MAX40;
            if (s < MIN40) return MIN40;
            return s;
        end
        return (s <<< 24) >>> 24;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int ln = 0; ln < 2; ln++) begin
            longint r, e16, e32;
            bit o16, o32;
            chk("R5/R6/R7", $sformatf("lane%0d acc", ln),
                longint'($signed(acc_out[ln*40+:40])), macc[ln]);
            r = (macc[ln] + 32768) >>> 16;
            o16 = (r > 32767) || (r < -32768);
            e16 = (r > 32767) ? 32767 : (r < -32768) ? -32768 : r;
            chk("R8/R9", $sformatf("lane%0d res16", ln),
                longint'($signed(res16_out[ln*16+:16])), e16);
            chk("R9", $sformatf("lane%0d ovf16", ln), longint'(ovf16[ln]), longint'(o16));
            o32 = (macc[ln] > 64'sd2147483647) || (macc[ln] < -64'sd2147483648);
            e32 = (macc[ln] > 64'sd2147483647) ? 64'sd2147483647 :
                  (macc[ln] < -64'sd2147483648) ? -64'sd2147483648 : macc[ln];
            chk("R10", $sformatf("lane%0d res32", ln),
                longint'($signed(res32_out[ln*32+:32])), e32);
            chk("R10", $sformatf("lane%0d ovf32", ln), longint'(ovf32[ln]), longint'(o32));
        end
    endtask

    // Each negedge: compare outputs with the model, then the stimulus for the
    // next edge is applied by the task and folded into the model.
    task automatic step(bit v, logic [31:0] wa, logic [31:0] wb, logic [1:0] ha,
                        logic [1:0] hb, logic [3:0] op, logic [1:0] sg, bit sat);
        @(negedge clk);
        compare_all();
        in_valid = v; opa_word = wa; opb_word = wb; hi_a = ha; hi_b = hb;
        op_sel = op; signed_mode = sg; sat_acc = sat;
        for (int ln = 0; ln < 2; ln++) macc[ln] = model_next(ln, macc[ln]);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        macc[0] = 0; macc[1] = 0;
        repeat (3) @(negedge clk);
        compare_all();                                  // R1 reset state
        rst_n = 1;
        // R2 half selection, R3 signed: lane0 hi*lo, lane1 lo*hi
        step(1, 32'hFFFF_0003, 32'h0005_7FFF, 2'b01, 2'b10, 4'b0101, 2'b11, 0);
        // R3 unsigned same words
        step(1, 32'hFFFF_0003, 32'h0005_7FFF, 2'b01, 2'b10, 4'b0101, 2'b00, 0);
        // R4 hold with strobe low, and code 00
        step(0, 32'h1234_5678, 32'h9ABC_DEF0, 2'b11, 2'b11, 4'b1010, 2'b11, 0);
        step(1, 32'h1234_5678, 32'h9ABC_DEF0, 2'b11, 2'b11, 4'b0000, 2'b11, 0);
        // R11 independence: lane0 adds, lane1 holds; then lane1 subtracts alone
        step(1, 32'h0000_0100, 32'h0000_0100, 2'b00, 2'b00, 4'b0010, 2'b11, 0);
        step(1, 32'h0000_0100, 32'h0000_0100, 2'b00, 2'b00, 4'b1100, 2'b11, 0);
        // R8 rounding: 0x8000 rounds up, 0x7FFF rounds down, negatives
        step(1, 32'h0000_0001, 32'h0000_8000, 2'b00, 2'b00, 4'b0101, 2'b00, 0);
        step(1, 32'h0000_0001, 32'h0000_7FFF, 2'b00, 2'b00, 4'b0101, 2'b00, 0);
        step(1, 32'h0000_FFFF, 32'h0000_7FFF, 2'b00, 2'b00, 4'b0101, 2'b11, 0);
        step(1, 32'h0000_8000, 32'h0000_8000, 2'b00, 2'b00, 4'b0101, 2'b11, 0);
        // R6 wrap: lane0 adds max unsigned, lane1 subtracts it, 140 times
        step(1, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 4'b0101, 2'b00, 0);
        for (int k = 0; k < 140; k++)
            step(1, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 4'b1110, 2'b00, 0);
        // R7 clamp at both ends
        step(1, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 4'b0101, 2'b00, 1);
        for (int k = 0; k < 140; k++)
            step(1, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 4'b1110, 2'b00, 1);
        // R9/R10 near the 16/32-bit limits in both directions
        step(1, 32'h0000_7FFF, 32'h0000_7FFF, 2'b00, 2'b00, 4'b1010, 2'b11, 1);
        // random traffic on all controls, R5 back-to-back operation
        for (int k = 0; k < 3000; k++)
            step(($urandom % 8) != 0, $urandom, $urandom, 2'($urandom), 2'($urandom),
                 4'($urandom), 2'($urandom), 1'($urandom));
        step(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        running = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule